// File: doc/BRIEF.md
# Four-Phase Control Word Sequencer

This block runs a wide horizontal control word through a fixed cycle of four timing phases, T1, T2, T3 and T4. The control store sits outside the block: the sequencer drives a word address, spends one load cycle latching the word presented to it, and then steps through the phases. Each phase normally lasts one clock. A per-phase flag in the word stretches that phase to two clocks, and an external wait input holds the last clock of a phase for as long as it stays high. A phase ends only when its minimum time has passed and wait is low. The datapath is not part of the block; it sees a one-hot phase level and a one-hot phase-end strobe.

The word names one phase as its end phase. When that phase ends, the sequencer issues a new-word fetch, unless the word is gated on the condition input and that input is low. Without a fetch the phases wrap from T4 back to T1. The address of the next word comes from one of four places, in this priority order: the single return register, the word's local immediate field, an interrupt vector, or the next-address counter. Branching is two-way on one condition input. A call keeps exactly one return address.

The next-address counter is updated on every fetch, and the word's operation picks its new value. The local immediate field is a copy that the datapath may overwrite while the word runs. A fetch reloads it from the control store. One word field marks the phase in which an arithmetic or shift result is launched. The block flags that result as valid two phases later.

Top module: `nw_sequencer`

## Requirements
- R1: While `rst_ni` is low, `addr_o` and `cnt_o` are 0, `load_o` is 1, and `phase_o`, `phase_end_o`, `irq_ack_o` and `res_vld_o` are 0.
- R2: `load_o` is high for exactly one cycle after reset and after each fetch, with `phase_o` zero. The word latched is the one at `addr_o`. The next cycle is T1 (`phase_o`=0001). Word bit fields: imm[9:0], stretch[13:10] (bit 10+k for phase k, T1 is k=0), end_en[14], end_ph[16:15], gate[17], jump[18], branch[19], call[20], ret[21], cnt_op[23:22], res_en[24], res_ph[26:25].
- R3: Without a fetch, a phase end advances `phase_o` one position, and T4 wraps to T1. This includes an end phase whose gate bit is set while `cond_i` is low.
- R4: A phase whose stretch bit is set lasts two cycles when `wait_i` is low. An unflagged phase lasts one cycle.
- R5: `phase_end_o` carries the current phase bit only in a phase's final cycle. While `wait_i` is high, `phase_end_o` is 0 and the phase is held.
- R6: A fetch happens when end phase end_ph ends with end_en set, provided gate is clear or `cond_i` is high. In the cycle after the fetch, `addr_o` shows the chosen address. The sources, highest priority first, are: ret (the return register); jump, or branch with `cond_i` high (the local immediate); any pending interrupt; and otherwise the updated counter.
- R7: When an interrupt supplies the address, the lowest pending index i wins and the address is VEC_BASE+i. In the fetch cycle, `irq_ack_o` has bit i set and no other bit. At all other times `irq_ack_o` is 0.
- R8: `cnt_o` changes only at a fetch. cnt_op selects the new value: 0 keeps it, 1 adds one, 2 loads the local immediate, 3 loads `bus_i`.
- R9: A fetch from a word with call set writes the updated counter into the single return register. A second call made before a return overwrites that value.
- R10: The branch is two-way. With the branch bit set, `cond_i` high selects the immediate and `cond_i` low falls through to the interrupt or counter source.
- R11: `kn_wr_i` replaces the local immediate with `kn_wd_i` from the next cycle on. The next word load restores the stored value.
- R12: If res_en is set, `res_vld_o` is high for the whole phase that starts two phase ends after the end of phase res_ph. This can be after a wrap. It is low in every other cycle, and a fetch cancels a pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 27 | Control word read at `addr_o` |
| bus_i | input | 10 | Data word for counter loading |
| cond_i | input | 1 | Branch and gate condition |
| wait_i | input | 1 | Holds the current phase while high |
| irq_i | input | NIRQ | Pending interrupt lines |
| kn_wr_i | input | 1 | Overwrite strobe for the local immediate |
| kn_wd_i | input | 10 | Value for the local immediate |
| addr_o | output | 10 | Control word address |
| cnt_o | output | 10 | Next-address counter |
| load_o | output | 1 | Word load cycle |
| phase_o | output | 4 | One-hot phase level, T1 in bit 0 |
| phase_end_o | output | 4 | One-hot final-cycle strobe |
| irq_ack_o | output | NIRQ | One-hot vector acknowledge |
| res_vld_o | output | 1 | Result valid |

## Verification
A wrong phase or stretch count shows up on `phase_o` and `phase_end_o` in the very next cycle. A wrong selector decision or a wrong counter value shows up on `addr_o` and `cnt_o` one cycle after the fetch. A corrupted return register or local immediate stays hidden until a later return, jump or counter load uses it, which may be several words later. For that reason the directed program follows a fixed chain of addresses through calls, an overwritten return, a patched immediate and both branch outcomes. Randomized words and inputs then compare every output against a behavioural model on every cycle.

// File: rtl/nw_pkg.sv
`timescale 1ns/1ps
package nw_pkg;
  localparam int AW  = 10;
  localparam int NPH = 4;
  localparam int PW  = $clog2(NPH);

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_IMM  = 2'd2,
    CNT_BUS  = 2'd3
  } cnt_op_e;

  typedef struct packed {
    logic [PW-1:0]  res_ph;
    logic           res_en;
    cnt_op_e        cnt_op;
    logic           ret;
    logic           call;
    logic           br;
    logic           jmp;
    logic           gate;
    logic [PW-1:0]  end_ph;
    logic           end_en;
    logic [NPH-1:0] stretch;
    logic [AW-1:0]  imm;
  } nword_t;

  localparam int WORD_W = $bits(nword_t);
endpackage

// File: rtl/nw_phase_timer.sv
`timescale 1ns/1ps
module nw_phase_timer
  import nw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] stretch_i,
  input  logic           wait_i,
  input  logic           end_en_i,
  input  logic [PW-1:0]  end_ph_i,
  input  logic           gate_i,
  input  logic           cond_i,
  output logic           load_o,
  output logic [PW-1:0]  ph_o,
  output logic           done_o,
  output logic           fetch_o,
  output logic [NPH-1:0] phase_o,
  output logic [NPH-1:0] phase_end_o
);
  logic          ld_q;
  logic [PW-1:0] ph_q;
  logic          sub_q;
  logic          long_ph;
  logic          done;
  logic          fetch;

  assign long_ph = stretch_i[ph_q];
  assign done    = !ld_q && (sub_q || !long_ph) && !wait_i;
  assign fetch   = done && end_en_i && (ph_q == end_ph_i) && (!gate_i || cond_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q  <= 1'b1;
      ph_q  <= '0;
      sub_q <= 1'b0;
    end else if (ld_q) begin
      ld_q  <= 1'b0;
      ph_q  <= '0;
      sub_q <= 1'b0;
    end else if (!done) begin
      if (long_ph) sub_q <= 1'b1;
    end else begin
      sub_q <= 1'b0;
      if (fetch) ld_q <= 1'b1;
      else       ph_q <= (ph_q == PW'(NPH-1)) ? '0 : PW'(ph_q + 1'b1);
    end
  end

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    assign phase_o[k]     = !ld_q && (ph_q == PW'(k));
    assign phase_end_o[k] = done && (ph_q == PW'(k));
  end

  assign load_o  = ld_q;
  assign ph_o    = ph_q;
  assign done_o  = done;
  assign fetch_o = fetch;

  // R2
  load_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (!load_o && phase_o == NPH'(1)));
  // R3
  phase_rot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fetch_o) |=> phase_o == {$past(phase_o[NPH-2:0]), $past(phase_o[NPH-1])});
  // R4
  stretch_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_end_o & stretch_i) != '0) |-> $past(phase_o) == phase_o);
  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |-> phase_end_o == '0);
endmodule

// File: rtl/nw_next_addr.sv
`timescale 1ns/1ps
module nw_next_addr
  import nw_pkg::*;
#(
  parameter int            NIRQ     = 30,
  parameter logic [AW-1:0] VEC_BASE = 10'h3C0,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_i,
  input  logic            jmp_i,
  input  logic            br_i,
  input  logic            ret_i,
  input  logic            call_i,
  input  cnt_op_e         cnt_op_i,
  input  logic            cond_i,
  input  logic [AW-1:0]   imm_i,
  input  logic [AW-1:0]   bus_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic [AW-1:0]   addr_o,
  output logic [AW-1:0]   cnt_o,
  output logic [NIRQ-1:0] irq_ack_o
);
  localparam int IW = $clog2(NIRQ);

  logic [AW-1:0] addr_q, cnt_q, ret_q;
  logic [AW-1:0] cnt_nx, sel;
  logic [IW-1:0] irq_idx;
  logic          irq_any, use_irq, to_imm;

  always_comb begin
    irq_any = 1'b0;
    irq_idx = '0;
    for (int i = NIRQ-1; i >= 0; i--) begin
      if (irq_i[i]) begin
        irq_any = 1'b1;
        irq_idx = IW'(i);
      end
    end
  end

  always_comb begin
    unique case (cnt_op_i)
      CNT_HOLD: cnt_nx = cnt_q;
      CNT_INC:  cnt_nx = cnt_q + AW'(1);
      CNT_IMM:  cnt_nx = imm_i;
      default:  cnt_nx = bus_i;
    endcase
  end

  assign to_imm  = !ret_i && (jmp_i || (br_i && cond_i));
  assign use_irq = !ret_i && !to_imm && irq_any;

  always_comb begin
    if (ret_i)        sel = ret_q;
    else if (to_imm)  sel = imm_i;
    else if (use_irq) sel = VEC_BASE + AW'(irq_idx);
    else              sel = cnt_nx;
  end

  for (genvar k = 0; k < NIRQ; k++) begin : g_ack
    assign irq_ack_o[k] = fetch_i && use_irq && (irq_idx == IW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= RST_ADDR;
      cnt_q  <= '0;
      ret_q  <= '0;
    end else if (fetch_i) begin
      addr_q <= sel;
      cnt_q  <= cnt_nx;
      if (call_i) ret_q <= cnt_nx;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  // R7
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));
  // R7
  ack_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o & ~irq_i) == '0);
  // R8
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && cnt_op_i == CNT_INC) |=> cnt_o == AW'($past(cnt_o) + 1'b1));
  // R8
  cnt_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |=> $stable(cnt_o));
  // R6
  jump_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && jmp_i && !ret_i) |=> addr_o == $past(imm_i));
endmodule

// File: rtl/nw_result_track.sv
`timescale 1ns/1ps
module nw_result_track
  import nw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          done_i,
  input  logic          fetch_i,
  input  logic [PW-1:0] ph_i,
  input  logic          res_en_i,
  input  logic [PW-1:0] res_ph_i,
  output logic          res_vld_o
);
  logic v1_q, v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (load_i || (done_i && fetch_i)) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (done_i) begin
      v2_q <= v1_q;
      v1_q <= res_en_i && (ph_i == res_ph_i);
    end
  end

  assign res_vld_o = v2_q;

  // R12
  res_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> !load_i);
  // R12
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !done_i) |=> res_vld_o);
endmodule

// File: rtl/nw_sequencer.sv
`timescale 1ns/1ps
module nw_sequencer
  import nw_pkg::*;
#(
  parameter int            NIRQ     = 30,
  parameter logic [AW-1:0] VEC_BASE = 10'h3C0,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic [AW-1:0]     bus_i,
  input  logic              cond_i,
  input  logic              wait_i,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic              kn_wr_i,
  input  logic [AW-1:0]     kn_wd_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     cnt_o,
  output logic              load_o,
  output logic [NPH-1:0]    phase_o,
  output logic [NPH-1:0]    phase_end_o,
  output logic [NIRQ-1:0]   irq_ack_o,
  output logic              res_vld_o
);
  nword_t        cur_q;
  logic          load, done, fetch;
  logic [PW-1:0] ph;

  // local immediate is rewritable; a load restores it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q     <= '0;
    else if (load)    cur_q     <= nword_t'(word_i);
    else if (kn_wr_i) cur_q.imm <= kn_wd_i;
  end

  nw_phase_timer i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stretch_i   (cur_q.stretch),
    .wait_i      (wait_i),
    .end_en_i    (cur_q.end_en),
    .end_ph_i    (cur_q.end_ph),
    .gate_i      (cur_q.gate),
    .cond_i      (cond_i),
    .load_o      (load),
    .ph_o        (ph),
    .done_o      (done),
    .fetch_o     (fetch),
    .phase_o     (phase_o),
    .phase_end_o (phase_end_o)
  );

  nw_next_addr #(
    .NIRQ     (NIRQ),
    .VEC_BASE (VEC_BASE),
    .RST_ADDR (RST_ADDR)
  ) i_next (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fetch_i   (fetch),
    .jmp_i     (cur_q.jmp),
    .br_i      (cur_q.br),
    .ret_i     (cur_q.ret),
    .call_i    (cur_q.call),
    .cnt_op_i  (cur_q.cnt_op),
    .cond_i    (cond_i),
    .imm_i     (cur_q.imm),
    .bus_i     (bus_i),
    .irq_i     (irq_i),
    .addr_o    (addr_o),
    .cnt_o     (cnt_o),
    .irq_ack_o (irq_ack_o)
  );

  nw_result_track i_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .done_i    (done),
    .fetch_i   (fetch),
    .ph_i      (ph),
    .res_en_i  (cur_q.res_en),
    .res_ph_i  (cur_q.res_ph),
    .res_vld_o (res_vld_o)
  );

  assign load_o = load;

  // R2
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (phase_o == '0 && phase_end_o == '0 && irq_ack_o == '0));
  // R6
  addr_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(addr_o) || load_o);
endmodule

// File: tb/test_nw_sequencer.sv
`timescale 1ns/1ps
module test_nw_sequencer;
  localparam int NIRQ = 30;
  localparam int VEC  = 960;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] word;
  logic [9:0]  bus = '0;
  logic        cond = 1'b0;
  logic        wt = 1'b0;
  logic [NIRQ-1:0] irq = '0;
  logic        kn_wr = 1'b0;
  logic [9:0]  kn_wd = '0;
  logic [9:0]  addr, cnt;
  logic        load, res_vld;
  logic [3:0]  phase, phase_end;
  logic [NIRQ-1:0] ack;

  logic [26:0] mem [0:1023];
  assign word = mem[addr];

  always #5 clk = ~clk;

  nw_sequencer #(.NIRQ(NIRQ), .VEC_BASE(10'(VEC)), .RST_ADDR(10'd0)) i_nw_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .bus_i(bus), .cond_i(cond),
    .wait_i(wt), .irq_i(irq), .kn_wr_i(kn_wr), .kn_wd_i(kn_wd),
    .addr_o(addr), .cnt_o(cnt), .load_o(load), .phase_o(phase),
    .phase_end_o(phase_end), .irq_ack_o(ack), .res_vld_o(res_vld)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [26:0] mkw(int imm, int str, int en, int eph, int gate, int jmp,
                                      int br, int call, int ret, int op, int ren, int rph);
    logic [26:0] w;
    w = '0;
    w[9:0] = imm[9:0]; w[13:10] = str[3:0]; w[14] = en[0]; w[16:15] = eph[1:0];
    w[17] = gate[0]; w[18] = jmp[0]; w[19] = br[0]; w[20] = call[0]; w[21] = ret[0];
    w[23:22] = op[1:0]; w[24] = ren[0]; w[26:25] = rph[1:0];
    return w;
  endfunction

  // behavioural reference model
  bit          m_ld;
  int          m_ph, m_sub, m_addr, m_cnt, m_ret, m_imm;
  bit          m_v1, m_v2;
  logic [26:0] m_w;
  bit          e_done, e_fetch, e_irq;
  int          e_idx, e_sel, e_cnt;

  task automatic eval();
    bit taken;
    e_done  = !m_ld && (m_sub == 1 || !m_w[10 + m_ph]) && !wt;
    e_fetch = e_done && m_w[14] && (m_ph == int'(m_w[16:15])) && (!m_w[17] || cond);
    e_idx = -1;
    for (int i = 0; i < NIRQ; i++) if (irq[i] && e_idx < 0) e_idx = i;
    case (m_w[23:22])
      2'd0: e_cnt = m_cnt;
      2'd1: e_cnt = (m_cnt + 1) % 1024;
      2'd2: e_cnt = m_imm;
      default: e_cnt = int'(bus);
    endcase
    taken = m_w[19] && cond;
    e_irq = 0;
    if (m_w[21]) e_sel = m_ret;
    else if (m_w[18] || taken) e_sel = m_imm;
    else if (e_idx >= 0) begin e_sel = VEC + e_idx; e_irq = 1; end
    else e_sel = e_cnt;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ld = 1; m_ph = 0; m_sub = 0; m_addr = 0; m_cnt = 0; m_ret = 0;
      m_imm = 0; m_v1 = 0; m_v2 = 0; m_w = '0;
    end else begin
      eval();
      if (m_ld) begin
        m_w = word; m_imm = int'(word[9:0]);
        m_ld = 0; m_ph = 0; m_sub = 0; m_v1 = 0; m_v2 = 0;
      end else begin
        if (kn_wr) m_imm = int'(kn_wd);
        if (!e_done) begin
          if (m_w[10 + m_ph]) m_sub = 1;
        end else begin
          m_sub = 0;
          if (e_fetch) begin
            m_ld = 1; m_addr = e_sel; m_cnt = e_cnt;
            if (m_w[20]) m_ret = e_cnt;
            m_v1 = 0; m_v2 = 0;
          end else begin
            m_v2 = m_v1;
            m_v1 = m_w[24] && (m_ph == int'(m_w[26:25]));
            m_ph = (m_ph + 1) % 4;
          end
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] ep, ee;
      logic [NIRQ-1:0] ea;
      eval();
      ep = m_ld ? 4'b0 : 4'(1 << m_ph);
      ee = e_done ? 4'(1 << m_ph) : 4'b0;
      ea = (e_fetch && e_irq) ? NIRQ'(1) << e_idx : '0;
      chk(addr == 10'(m_addr), "R6 addr_o", addr, m_addr);
      chk(load == m_ld, "R2 load_o", load, m_ld);
      chk(phase == ep, "R3 phase_o", phase, ep);
      chk(phase_end == ee, "R5 phase_end_o", phase_end, ee);
      chk(ack == ea, "R7 irq_ack_o", ack, ea);
      chk(res_vld == m_v2, "R12 res_vld_o", res_vld, m_v2);
      chk(cnt == 10'(m_cnt), "R8 cnt_o", cnt, m_cnt);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_load(input int exp, input string tag);
    int n = 0;
    do begin step(); n++; end while (!load && n < 300);
    chk(load && addr == 10'(exp), tag, addr, exp);
  endtask

  initial begin
    int t2 = 0, good_v = 0, bad_v = 0, wraps = 0;
    for (int a = 0; a < 1024; a++) mem[a] = mkw(0, 0, 1, 3, 0, 0, 0, 0, 0, 1, 0, 0);
    mem[0]   = mkw(0, 4'b0010, 1, 3, 0, 0, 0, 0, 0, 1, 1, 0);
    mem[1]   = mkw(10, 0, 1, 1, 0, 1, 0, 1, 0, 1, 0, 0);
    mem[10]  = mkw(30, 0, 1, 3, 0, 0, 0, 0, 0, 2, 0, 0);
    mem[20]  = mkw(40, 0, 1, 2, 0, 0, 1, 0, 0, 3, 0, 0);
    mem[50]  = mkw(60, 0, 1, 3, 0, 0, 1, 0, 0, 1, 0, 0);
    mem[60]  = mkw(0, 0, 1, 3, 0, 0, 0, 0, 1, 0, 0, 0);
    mem[962] = mkw(70, 0, 1, 3, 0, 1, 0, 1, 0, 0, 0, 0);
    mem[70]  = mkw(80, 0, 1, 3, 0, 1, 0, 1, 0, 1, 0, 0);
    mem[80]  = mkw(0, 0, 1, 3, 0, 0, 0, 0, 1, 0, 0, 0);
    mem[53]  = mkw(0, 4'b0100, 1, 1, 1, 0, 0, 0, 0, 1, 1, 3);

    repeat (3) step();
    // R1 reset state
    chk(addr == 0 && cnt == 0, "R1 reset addr/cnt", {addr, cnt}, 0);
    chk(load == 1 && phase == 0 && phase_end == 0, "R1 reset load/phase", {load, phase, phase_end}, 9'h100);
    chk(ack == 0 && res_vld == 0, "R1 reset ack/res", {ack, res_vld}, 0);
    rst_n = 1'b1;

    // word 0: T2 stretched, result launched in T1
    do begin
      step();
      if (phase == 4'b0010) t2++;
      if (res_vld && phase == 4'b0100) good_v++;
      if (res_vld && phase != 4'b0100) bad_v++;
    end while (!load);
    chk(addr == 1, "R6 sequential after word 0", addr, 1);
    chk(t2 == 2, "R4 stretched T2 length", t2, 2);
    chk(good_v == 1 && bad_v == 0, "R12 result in T3 only", {good_v, bad_v}, 64'h100000000);

    expect_load(10, "R9 call jump target");
    step(); kn_wr = 1'b1; kn_wd = 10'd20;
    step(); kn_wr = 1'b0;
    expect_load(20, "R11 patched immediate loads counter");
    bus = 10'd50; cond = 1'b0;
    expect_load(50, "R10 branch not taken uses bus counter");
    cond = 1'b1;
    expect_load(60, "R10 branch taken");
    cond = 1'b0;
    expect_load(2, "R9 return address");
    irq = (NIRQ'(1) << 5) | (NIRQ'(1) << 2);
    expect_load(VEC + 2, "R7 lowest pending vector");
    irq = NIRQ'(1) << 5;
    expect_load(70, "R6 jump beats pending interrupt");
    irq = '0;
    expect_load(80, "R9 second call");
    expect_load(53, "R9 overwritten return");
    cond = 1'b0;
    for (int i = 0; i < 14; i++) begin
      wt = (i >= 4 && i < 7);
      step();
      if (phase_end == 4'b1000) wraps++;
    end
    wt = 1'b0;
    chk(wraps >= 2, "R3 gated word wraps T4 to T1", wraps, 2);
    cond = 1'b1;
    expect_load(54, "R6 gated fetch");
    cond = 1'b0;

    // randomized words and inputs
    for (int a = 0; a < 1024; a++) begin
      logic [26:0] r;
      r = 27'($urandom);
      r[14] = 1'b1;
      mem[a] = r;
    end
    for (int i = 0; i < 4000; i++) begin
      step();
      wt    = ($urandom % 4) == 0;
      cond  = $urandom % 2;
      kn_wr = ($urandom % 10) == 0;
      kn_wd = 10'($urandom);
      bus   = 10'($urandom);
      irq   = (($urandom % 6) == 0) ? (NIRQ'(1) << ($urandom % NIRQ)) : '0;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule